// File: doc/BRIEF.md
# Serial Command Front End for a Cascadable LED Driver

This block sits between the serial pins of a chainable LED driver and the rest of the chip. A 16-bit shift register takes the serial data input (SDI) on every rising edge of the data clock. While the latch-enable line (LE) is high, a counter tallies those rising edges. On the first rising edge that finds LE low again, the tally is turned into a command.

The commands are:
- a data latch, which hands the shifted word to the frame store;
- a frame-sync strobe;
- a write to either of two configuration words;
- a read-back of either configuration word;
- the start of an open-circuit test;
- the capture of that test's result.

A configuration write takes effect only when the LE pulse just before it was the pre-activation command. The serial output (SDO) is always the most significant bit of the shift register, so several devices can be chained: each one's SDO feeds the next one's SDI, and every transaction is 16 bits per device.

The block does not contain the PWM engine or the analog detection. The test result comes in as a 16-bit input.

Top module: `ledfe_cmd_frontend`

## Requirements
- R1: After a synchronous active-low reset, the outputs are as follows. cfg1 = 0x002B and cfg2 = 0x0000. test_active, both strobes and sdo are 0. The decoded fields come from the cfg1 reset value.
- R2: An LE pulse of exactly 14 rising edges arms the block. If the next pulse is 4 edges, the 16-bit word that was shifted in is written to cfg1. If the next pulse is 8 edges, the word is written to cfg2.
- R3: A 4- or 8-edge pulse that does not come directly after an arming pulse changes neither register. Any other pulse between the arming pulse and the write cancels the armed state. The arming pulse and the ignored write pulses raise no strobe.
- R4: A 5-edge pulse loads cfg1 into the shifter, and a 9-edge pulse loads cfg2. The loaded word then appears on sdo MSB first, one bit per clock, whatever SDI carries meanwhile.
- R5: A 7-edge pulse sets test_active. A 1-edge pulse clears test_active and loads open_result into the shifter, which is then sent out MSB first (0 = open channel, 1 = normal).
- R6: A 2- or 3-edge pulse raises sync_stb. Any count not given a meaning in R2 to R5 raises latch_stb, and latch_word then holds the word that was shifted in.
- R7: sdo updates on the falling clock edge to the MSB of the shifter. With LE low, a word presented on sdi reappears on sdo, MSB first, starting 16 clocks later, so devices can be cascaded.
- R8: The decoded fields come from cfg1: deghost_en is bit 15, gray14_en is bit 7 and gain_code is bits 5:0.
- R9: Each strobe is high for exactly one clock, in the cycle after the decode edge. The two strobes are never high together, and neither is raised when LE was high at the decode edge.
- R10: The edge counter saturates instead of wrapping. A pulse longer than the counter range still decodes as a data latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk | input | 1 | Serial data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch enable; its high length in edges selects the command |
| open_result | input | 16 | Open-circuit test result, 0 = open, 1 = normal |
| sdo | output | 1 | Serial data out (shifter MSB, falling-edge timed) |
| latch_stb | output | 1 | One-cycle data-latch strobe |
| latch_word | output | 16 | Word captured with the last data latch |
| sync_stb | output | 1 | One-cycle frame-sync strobe |
| test_active | output | 1 | Open-circuit test running; downstream channels blank |
| cfg1 | output | 16 | Configuration word 1 |
| cfg2 | output | 16 | Configuration word 2 |
| deghost_en | output | 1 | De-ghost enable (cfg1 bit 15) |
| gray14_en | output | 1 | 14-bit grayscale select (cfg1 bit 7) |
| gain_code | output | 6 | Current-gain code (cfg1 bits 5:0) |

## Verification
The hard cases are around the armed state. A write pulse with no arming pulse before it must leave the configuration unchanged; if the design accepted it, a stray pulse could reprogram the driver. A sync pulse or a latch pulse between the arm and the write must also cancel it; if the design only cleared the armed state on the write itself, a stale arm would let the write through.

The bench sends a 33-edge pulse. A counter that wraps would see 1 edge and take it as a result capture instead of a data latch. The bench also reads back while driving SDI high, which would corrupt the read word in a shifter that takes SDI in on the load edge. Finally, it checks the 16-clock delay from sdi to sdo, which exposes an sdo taken from the wrong bit or on the wrong edge.

// File: rtl/ledfe_pkg.sv
`timescale 1ns/1ps
// Package: shared command codes and LE pulse lengths for the serial front end.
// Assumes: commands are told apart only by the number of rising clock edges
// seen while LE is high.
package ledfe_pkg;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_LATCH,
        CMD_SYNC,
        CMD_ARM,
        CMD_WR1,
        CMD_WR2,
        CMD_RD1,
        CMD_RD2,
        CMD_TSTART,
        CMD_TRESULT
    } ledfe_cmd_t;

    localparam int LEN_TRESULT = 1;
    localparam int LEN_SYNC_A  = 2;
    localparam int LEN_SYNC_B  = 3;
    localparam int LEN_WR1     = 4;
    localparam int LEN_RD1     = 5;
    localparam int LEN_TSTART  = 7;
    localparam int LEN_WR2     = 8;
    localparam int LEN_RD2     = 9;
    localparam int LEN_ARM     = 14;

endpackage

// File: rtl/ledfe_le_decoder.sv
`timescale 1ns/1ps
// Module: ledfe_le_decoder
// Counts the rising clock edges that see LE high. On the first edge that sees
// LE low, it presents one command for that single cycle.
// Assumes: CNT_W is wide enough for the longest command length (14). The
// count saturates so that long pulses never alias to a short command.
module ledfe_le_decoder
    import ledfe_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic       dclk,
    input  logic       rst_n,
    input  logic       le,
    output ledfe_cmd_t cmd
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Edge counter: counts while LE is high, holds at its maximum, clears when LE is low.
    always_ff @(posedge dclk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (le) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    // Decode: active only on the first low-LE edge after a pulse.
    always_comb begin
        cmd = CMD_NONE;
        if (!le && (cnt_q != '0)) begin
            if      (cnt_q == CNT_W'(LEN_TRESULT)) cmd = CMD_TRESULT;
            else if (cnt_q == CNT_W'(LEN_SYNC_A))  cmd = CMD_SYNC;
            else if (cnt_q == CNT_W'(LEN_SYNC_B))  cmd = CMD_SYNC;
            else if (cnt_q == CNT_W'(LEN_WR1))     cmd = CMD_WR1;
            else if (cnt_q == CNT_W'(LEN_RD1))     cmd = CMD_RD1;
            else if (cnt_q == CNT_W'(LEN_TSTART))  cmd = CMD_TSTART;
            else if (cnt_q == CNT_W'(LEN_WR2))     cmd = CMD_WR2;
            else if (cnt_q == CNT_W'(LEN_RD2))     cmd = CMD_RD2;
            else if (cnt_q == CNT_W'(LEN_ARM))     cmd = CMD_ARM;
            else                                   cmd = CMD_LATCH;
        end
    end

endmodule

// File: rtl/ledfe_shifter.sv
`timescale 1ns/1ps
// Module: ledfe_shifter
// Serial shift register, MSB first. A parallel load replaces the shift on the
// load edge, so the serial input on that edge is dropped. The serial output is
// the MSB, re-timed on the falling edge so that a chained device sees a stable bit.
// Assumes: load is a single-cycle pulse from the command decoder.
module ledfe_shifter #(
    parameter int W = 16
) (
    input  logic         dclk,
    input  logic         rst_n,
    input  logic         sdi,
    input  logic         load,
    input  logic [W-1:0] load_word,
    output logic [W-1:0] word,
    output logic         sdo
);

    logic [W-1:0] shift_q;
    logic         sdo_q;

    // Shift path: parallel load has priority over the serial shift.
    always_ff @(posedge dclk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (load) begin
            shift_q <= load_word;
        end else begin
            shift_q <= {shift_q[W-2:0], sdi};
        end
    end

    // Output re-timing: present the MSB from the falling edge onward.
    always_ff @(negedge dclk) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else begin
            sdo_q <= shift_q[W-1];
        end
    end

    assign word = shift_q;
    assign sdo  = sdo_q;

endmodule

// File: rtl/ledfe_cfg_regs.sv
`timescale 1ns/1ps
// Module: ledfe_cfg_regs
// Holds the two configuration words and the pre-activation (armed) state.
// A write is honoured only when the command just before it armed the block;
// any other command clears the armed state.
// Assumes: cmd is valid for exactly one cycle per LE pulse.
module ledfe_cfg_regs
    import ledfe_pkg::*;
#(
    parameter int         W        = 16,
    parameter logic [W-1:0] CFG1_RST = 16'h002B,
    parameter logic [W-1:0] CFG2_RST = 16'h0000
) (
    input  logic         dclk,
    input  logic         rst_n,
    input  ledfe_cmd_t   cmd,
    input  logic [W-1:0] word,
    output logic [W-1:0] cfg1,
    output logic [W-1:0] cfg2,
    output logic         armed
);

    logic         armed_q;
    logic [W-1:0] cfg1_q;
    logic [W-1:0] cfg2_q;

    // Armed state: set by the arming command, cleared by any other command.
    always_ff @(posedge dclk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (cmd == CMD_ARM) begin
            armed_q <= 1'b1;
        end else if (cmd != CMD_NONE) begin
            armed_q <= 1'b0;
        end
    end

    // Configuration words: written only when the block is armed.
    always_ff @(posedge dclk) begin
        if (!rst_n) begin
            cfg1_q <= CFG1_RST;
            cfg2_q <= CFG2_RST;
        end else if (armed_q) begin
            if (cmd == CMD_WR1) cfg1_q <= word;
            if (cmd == CMD_WR2) cfg2_q <= word;
        end
    end

    assign cfg1  = cfg1_q;
    assign cfg2  = cfg2_q;
    assign armed = armed_q;

endmodule

// File: rtl/ledfe_cmd_frontend.sv
`timescale 1ns/1ps
// Module: ledfe_cmd_frontend (top)
// Serial command front end. It decodes LE pulse lengths into commands,
// keeps the configuration words, chooses what the shifter loads for
// read-back and test results, and issues one-cycle strobes and the
// test-active level.
// Assumes: every input is synchronous to dclk; the field positions need DATA_W = 16.
module ledfe_cmd_frontend
    import ledfe_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              dclk,
    input  logic              rst_n,
    input  logic              sdi,
    input  logic              le,
    input  logic [DATA_W-1:0] open_result,
    output logic              sdo,
    output logic              latch_stb,
    output logic [DATA_W-1:0] latch_word,
    output logic              sync_stb,
    output logic              test_active,
    output logic [DATA_W-1:0] cfg1,
    output logic [DATA_W-1:0] cfg2,
    output logic              deghost_en,
    output logic              gray14_en,
    output logic [5:0]        gain_code
);

    ledfe_cmd_t        cmd;
    logic [DATA_W-1:0] shift_word;
    logic [DATA_W-1:0] load_word;
    logic              load;
    logic              arm_state;
    logic              latch_q;
    logic              sync_q;
    logic              test_q;
    logic [DATA_W-1:0] latch_word_q;

    ledfe_le_decoder #(.CNT_W(CNT_W)) u_dec (
        .dclk (dclk),
        .rst_n(rst_n),
        .le   (le),
        .cmd  (cmd)
    );

    // Load select: a read-back or a test result replaces the shift contents.
    always_comb begin
        load      = 1'b1;
        load_word = '0;
        case (cmd)
            CMD_RD1:     load_word = cfg1;
            CMD_RD2:     load_word = cfg2;
            CMD_TRESULT: load_word = open_result;
            default:     load = 1'b0;
        endcase
    end

    ledfe_shifter #(.W(DATA_W)) u_shift (
        .dclk     (dclk),
        .rst_n    (rst_n),
        .sdi      (sdi),
        .load     (load),
        .load_word(load_word),
        .word     (shift_word),
        .sdo      (sdo)
    );

    ledfe_cfg_regs #(.W(DATA_W)) u_cfg (
        .dclk (dclk),
        .rst_n(rst_n),
        .cmd  (cmd),
        .word (shift_word),
        .cfg1 (cfg1),
        .cfg2 (cfg2),
        .armed(arm_state)
    );

    // Strobes: one cycle each, registered from the decode edge.
    always_ff @(posedge dclk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
            sync_q  <= 1'b0;
        end else begin
            latch_q <= (cmd == CMD_LATCH);
            sync_q  <= (cmd == CMD_SYNC);
        end
    end

    // Latched word: captured together with the data-latch strobe.
    always_ff @(posedge dclk) begin
        if (!rst_n) begin
            latch_word_q <= '0;
        end else if (cmd == CMD_LATCH) begin
            latch_word_q <= shift_word;
        end
    end

    // Test state: set by the test-start command, cleared by the result command.
    always_ff @(posedge dclk) begin
        if (!rst_n) begin
            test_q <= 1'b0;
        end else if (cmd == CMD_TSTART) begin
            test_q <= 1'b1;
        end else if (cmd == CMD_TRESULT) begin
            test_q <= 1'b0;
        end
    end

    assign latch_stb   = latch_q;
    assign sync_stb    = sync_q;
    assign latch_word  = latch_word_q;
    assign test_active = test_q;
    assign deghost_en  = cfg1[15];
    assign gray14_en   = cfg1[7];
    assign gain_code   = cfg1[5:0];

endmodule

// File: rtl/ledfe_cmd_frontend_chk.sv
`timescale 1ns/1ps
// Module: ledfe_cmd_frontend_chk
// Protocol checker bound to the front end. It relates the strobes, the
// configuration words and the armed state across clock edges.
// Assumes: it is attached only through the bind below.
module ledfe_cmd_frontend_chk #(
    parameter int DATA_W = 16
) (
    input logic              dclk,
    input logic              rst_n,
    input logic              le,
    input logic              latch_stb,
    input logic              sync_stb,
    input logic              test_active,
    input logic [DATA_W-1:0] cfg1,
    input logic [DATA_W-1:0] cfg2,
    input logic              arm_state
);

    assert_strobe_excl_R9: assert property (@(posedge dclk) disable iff (!rst_n)
        $onehot0({latch_stb, sync_stb}));

    assert_latch_single_R9: assert property (@(posedge dclk) disable iff (!rst_n)
        latch_stb |=> !latch_stb);

    assert_no_strobe_le_high_R6: assert property (@(posedge dclk) disable iff (!rst_n)
        $past(le) |-> !(latch_stb || sync_stb));

    assert_cfg1_needs_arm_R3: assert property (@(posedge dclk) disable iff (!rst_n)
        !$stable(cfg1) |-> $past(arm_state));

    assert_cfg2_needs_arm_R2: assert property (@(posedge dclk) disable iff (!rst_n)
        !$stable(cfg2) |-> $past(arm_state));

    assert_test_after_le_R5: assert property (@(posedge dclk) disable iff (!rst_n)
        $rose(test_active) |-> !$past(le));

endmodule

bind ledfe_cmd_frontend ledfe_cmd_frontend_chk #(.DATA_W(DATA_W)) u_chk (
    .dclk       (dclk),
    .rst_n      (rst_n),
    .le         (le),
    .latch_stb  (latch_stb),
    .sync_stb   (sync_stb),
    .test_active(test_active),
    .cfg1       (cfg1),
    .cfg2       (cfg2),
    .arm_state  (arm_state)
);

// File: tb/ledfe_cmd_frontend_bench.sv
`timescale 1ns/1ps
// Bench: walks a table of LE pulses with their expected strobes and
// configuration words, then runs directed tests for reset, read-back, the test
// sequence, the cascade delay, the field decode and counter saturation.
module ledfe_cmd_frontend_bench;

    logic        dclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        le = 1'b0;
    logic [15:0] open_result = 16'hBEEF;
    logic        sdo, latch_stb, sync_stb, test_active;
    logic        deghost_en, gray14_en;
    logic [15:0] latch_word, cfg1, cfg2;
    logic [5:0]  gain_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 dclk = ~dclk;

    ledfe_cmd_frontend u_ledfe_cmd_frontend (
        .dclk(dclk), .rst_n(rst_n), .sdi(sdi), .le(le), .open_result(open_result),
        .sdo(sdo), .latch_stb(latch_stb), .latch_word(latch_word), .sync_stb(sync_stb),
        .test_active(test_active), .cfg1(cfg1), .cfg2(cfg2), .deghost_en(deghost_en),
        .gray14_en(gray14_en), .gain_code(gain_code)
    );

    typedef struct packed {
        logic [15:0] data;
        logic [5:0]  edges;
        logic        exp_latch;
        logic        exp_sync;
        logic [15:0] exp_cfg1;
        logic [15:0] exp_cfg2;
    } vec_t;

    // Pulse table: data, LE edges, expected latch, sync, cfg1, cfg2.
    localparam vec_t VEC [14] = '{
        '{16'hA5A5, 6'd6,  1'b1, 1'b0, 16'h002B, 16'h0000}, // R6 latch
        '{16'h0000, 6'd3,  1'b0, 1'b1, 16'h002B, 16'h0000}, // R6 sync
        '{16'h0000, 6'd2,  1'b0, 1'b1, 16'h002B, 16'h0000}, // R6 sync
        '{16'hFFFF, 6'd14, 1'b0, 1'b0, 16'h002B, 16'h0000}, // R2 arm
        '{16'h8F2B, 6'd4,  1'b0, 1'b0, 16'h8F2B, 16'h0000}, // R2 write cfg1
        '{16'h1234, 6'd4,  1'b0, 1'b0, 16'h8F2B, 16'h0000}, // R3 unarmed write ignored
        '{16'h0000, 6'd14, 1'b0, 1'b0, 16'h8F2B, 16'h0000}, // R2 arm
        '{16'h5411, 6'd8,  1'b0, 1'b0, 16'h8F2B, 16'h5411}, // R2 write cfg2
        '{16'h0000, 6'd14, 1'b0, 1'b0, 16'h8F2B, 16'h5411}, // R3 arm
        '{16'h3C3C, 6'd10, 1'b1, 1'b0, 16'h8F2B, 16'h5411}, // R3 latch cancels arm
        '{16'h4444, 6'd8,  1'b0, 1'b0, 16'h8F2B, 16'h5411}, // R3 write ignored
        '{16'h0000, 6'd14, 1'b0, 1'b0, 16'h8F2B, 16'h5411}, // R3 arm
        '{16'h0000, 6'd2,  1'b0, 1'b1, 16'h8F2B, 16'h5411}, // R3 sync cancels arm
        '{16'h7777, 6'd4,  1'b0, 1'b0, 16'h8F2B, 16'h5411}  // R3 write ignored
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Shift a word MSB first with LE high for the last 'edges' bits, then drop
    // LE; returns just after the falling edge that follows the decode edge.
    task automatic pulse(input logic [15:0] d, input int edges);
        int total = (edges > 16) ? edges : 16;
        for (int i = total - 1; i >= 0; i--) begin
            @(negedge dclk);
            sdi = (i < 16) ? d[i] : 1'b0;
            le  = (i < edges);
        end
        @(negedge dclk);
        le  = 1'b0;
        sdi = 1'b0;
        @(negedge dclk);
        #1;
    endtask

    // Read 16 bits from sdo while SDI is held high.
    task automatic read_out(input string req, input logic [15:0] exp);
        for (int i = 15; i >= 0; i--) begin
            chk(req, {31'b0, sdo}, {31'b0, exp[i]});
            sdi = 1'b1;
            @(negedge dclk);
            #1;
        end
        sdi = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge dclk);
        #1;
        // R1 reset state
        chk("R1 cfg1", {16'b0, cfg1}, 32'h002B);
        chk("R1 cfg2", {16'b0, cfg2}, 32'h0000);
        chk("R1 flags", {28'b0, test_active, latch_stb, sync_stb, sdo}, 32'h0);
        chk("R1 gain", {26'b0, gain_code}, 32'h2B);
        @(negedge dclk);
        rst_n = 1'b1;

        // Table walk (R2, R3, R6, R9)
        for (int v = 0; v < 14; v++) begin
            pulse(VEC[v].data, int'(VEC[v].edges));
            chk("R6 latch_stb", {31'b0, latch_stb}, {31'b0, VEC[v].exp_latch});
            chk("R6 sync_stb", {31'b0, sync_stb}, {31'b0, VEC[v].exp_sync});
            if (VEC[v].exp_latch)
                chk("R6 latch_word", {16'b0, latch_word}, {16'b0, VEC[v].data});
            chk("R2 cfg1", {16'b0, cfg1}, {16'b0, VEC[v].exp_cfg1});
            chk("R2 cfg2", {16'b0, cfg2}, {16'b0, VEC[v].exp_cfg2});
            @(negedge dclk);
            #1;
            chk("R9 strobes one cycle", {30'b0, latch_stb, sync_stb}, 32'h0);
        end

        // R8 field decode from cfg1 = 0x8F2B
        chk("R8 fields", {23'b0, deghost_en, gray14_en, 1'b0, gain_code}, {23'b0, 1'b1, 1'b0, 1'b0, 6'h2B});

        // R4 read-back with SDI held high
        pulse(16'h0000, 5);
        read_out("R4 read cfg1", 16'h8F2B);
        pulse(16'h0000, 9);
        read_out("R4 read cfg2", 16'h5411);

        // R5 open-circuit test sequence
        pulse(16'h0000, 7);
        chk("R5 test start", {31'b0, test_active}, 32'h1);
        pulse(16'h0000, 1);
        chk("R5 test end", {31'b0, test_active}, 32'h0);
        read_out("R5 result", 16'hBEEF);

        // R7 cascade: a word on sdi reappears on sdo 16 clocks later
        for (int i = 15; i >= 0; i--) begin
            @(negedge dclk);
            sdi = 16'hC35A >> i;
        end
        for (int i = 15; i >= 0; i--) begin
            @(negedge dclk);
            #1;
            chk("R7 cascade", {31'b0, sdo}, {31'b0, 1'((16'hC35A >> i) & 1)});
            sdi = 1'b0;
        end

        // R8 fields after a new cfg1 write
        pulse(16'h0000, 14);
        pulse(16'h00BF, 4);
        chk("R8 fields 2", {23'b0, deghost_en, gray14_en, 1'b0, gain_code}, {23'b0, 1'b0, 1'b1, 1'b0, 6'h3F});

        // R10 saturation: 33 edges must latch, not capture a result
        pulse(16'h0F0F, 33);
        chk("R10 latch", {31'b0, latch_stb}, 32'h1);
        chk("R10 word", {16'b0, latch_word}, 32'h0F0F);
        chk("R10 no test change", {31'b0, test_active}, 32'h0);
        pulse(16'h1357, 20);
        chk("R10 latch 20", {16'b0, latch_word}, 32'h1357);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: count an expired run as a failure and still print the summary.
    initial begin
        repeat (50000) @(posedge dclk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule